// File: doc/BRIEF.md
# Plane Discrepancy Detector and Locator

This block sits at the output port of a switch built from several parallel crossbar planes and one spare plane. In each bit-clock cycle it receives one word from every active plane and one word from the spare plane. It also receives the running bit-cycle index of the current input-output connection and a mode bit. The spare carries redundant copies of active-plane data. In complement mode the active plane instead carries inverted data, and the spare then carries the real user word. In the same cycle the block restores the user words and checks the one redundant pair that the index selects.

Disagreements are counted per active plane across a programmable window of accepted words. The window may span several cell slots of the same connection. When the window closes, the block pulses a report to the fault manager and clears its counters. The report says that all planes agree, or that one active plane is faulty, or that the spare is faulty. It can also say that a single active plane disagreed but the window did not reach every plane, so the blame cannot be settled.

Top module: `plane_check_top`

## Requirements
- R1: In copy mode (cmp_mode=0), an accepted cycle with index t compares the spare word with the word of active plane t mod N_ACT; the two disagree when any bit differs.
- R2: In copy mode, user_words equals act_words in the same cycle, with plane p in bits [p*W +: W].
- R3: In complement mode (cmp_mode=1), the compared plane is (t/2) mod N_ACT. On even t the active word must equal the spare word. On odd t it must equal the bit inverse of the spare word of the previous accepted cycle.
- R4: In complement mode on odd t, the restored word of the compared plane is the spare word, and every other plane passes through unchanged, in the same cycle.
- R5: A window closes on the accepted cycle (in_valid=1) that brings the count of accepted cycles to max(win_len,1). Cycles with in_valid=0 are not counted. rpt_valid is high for exactly the one cycle after that edge.
- R6: If no plane disagreed in the window, rpt_status is 0 (none) and rpt_plane is 0.
- R7: If exactly one plane disagreed and every plane was compared at least once in the window, rpt_status is 1 (active fault) and rpt_plane is that plane.
- R8: If two or more distinct planes disagreed, rpt_status is 2 (spare fault) and rpt_plane is 0.
- R9: If exactly one plane disagreed and some plane was never compared in the window, rpt_status is 3 (ambiguous) and rpt_plane is the disagreeing plane.
- R10: All disagreement and coverage state clears when a window closes, so a clean window reports none after a faulty one.
- R11: Per-plane disagreement counters saturate at 2^CNT_W-1 and never wrap back to zero.
- R12: After reset, rpt_valid, rpt_status and rpt_plane are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Plane words are present this cycle |
| cmp_mode | input | 1 | 0 copy placement, 1 complement placement |
| bit_idx | input | IDX_W | Bit-cycle index of the current connection |
| win_len | input | WIN_W | Words per test window (0 acts as 1) |
| act_words | input | N_ACT*W | Active-plane words, plane p at [p*W +: W] |
| spare_word | input | W | Spare-plane word |
| user_words | output | N_ACT*W | Restored user words |
| rpt_valid | output | 1 | One-cycle pulse at window close |
| rpt_status | output | 2 | 0 none, 1 active, 2 spare, 3 ambiguous |
| rpt_plane | output | PW | Blamed active plane index |

## Verification
The restored words are combinational, so they are due in the same cycle as the plane words. The bench drives on the falling edge and reads user_words one nanosecond later. The report passes through a single register and is due one rising edge after the last accepted cycle of a window. The bench reads it at the falling edge that follows that rising edge, and at the next falling edge it confirms that the pulse has dropped. Within a window, rpt_valid is checked low on every cycle, and gap cycles are used to show that the window counts only accepted words.

// File: rtl/plane_check_pkg.sv
package plane_check_pkg;

  typedef enum logic [1:0] {
    ST_NONE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_SPARE  = 2'd2,
    ST_AMBIG  = 2'd3
  } loc_status_e;

  // plane whose redundant pair is checked at bit cycle t
  function automatic int unsigned target_plane(input int unsigned t,
                                               input logic comp,
                                               input int unsigned m);
    return comp ? ((t >> 1) % m) : (t % m);
  endfunction

endpackage

// File: rtl/pc_route.sv
module pc_route
  import plane_check_pkg::*;
#(
  parameter int N_ACT = 4,
  parameter int W     = 4,
  parameter int IDX_W = 16,
  parameter int PW    = 2
) (
  input  logic [N_ACT*W-1:0] act_words,
  input  logic [W-1:0]       spare_word,
  input  logic [W-1:0]       prev_spare,
  input  logic [IDX_W-1:0]   bit_idx,
  input  logic               cmp_mode,
  output logic [N_ACT*W-1:0] user_words,
  output logic [PW-1:0]      tgt_plane,
  output logic               mism
);

  logic         second;
  logic [W-1:0] ref_w;
  logic [W-1:0] sel_w;

  always_comb begin
    tgt_plane  = PW'(target_plane(32'(bit_idx), cmp_mode, N_ACT));
    second     = cmp_mode & bit_idx[0];
    ref_w      = second ? ~prev_spare : spare_word;
    sel_w      = act_words[tgt_plane*W +: W];
    mism       = (sel_w != ref_w);
    user_words = act_words;
    if (second) user_words[tgt_plane*W +: W] = spare_word;
  end

endmodule

// File: rtl/pc_tally.sv
module pc_tally #(
  parameter int N_ACT = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ACT-1:0] hit_vec,
  input  logic             mism,
  input  logic             clear,
  output logic [N_ACT-1:0] cnt_nz,
  output logic [N_ACT-1:0] seen_q
);

  for (genvar g = 0; g < N_ACT; g++) begin : g_plane
    logic [CNT_W-1:0] cnt;
    logic             inc;
    assign inc = hit_vec[g] & mism;

    always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
        cnt       <= '0;
        seen_q[g] <= 1'b0;
      end else begin
        if (inc && (cnt != {CNT_W{1'b1}})) cnt <= cnt + 1'b1;
        if (hit_vec[g]) seen_q[g] <= 1'b1;
      end
    end

    assign cnt_nz[g] = (cnt != '0);
  end

endmodule

// File: rtl/plane_check_top.sv
module plane_check_top
  import plane_check_pkg::*;
#(
  parameter int N_ACT = 4,
  parameter int W     = 4,
  parameter int CNT_W = 8,
  parameter int WIN_W = 16,
  parameter int IDX_W = 16,
  localparam int PW   = (N_ACT > 1) ? $clog2(N_ACT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               cmp_mode,
  input  logic [IDX_W-1:0]   bit_idx,
  input  logic [WIN_W-1:0]   win_len,
  input  logic [N_ACT*W-1:0] act_words,
  input  logic [W-1:0]       spare_word,
  output logic [N_ACT*W-1:0] user_words,
  output logic               rpt_valid,
  output logic [1:0]         rpt_status,
  output logic [PW-1:0]      rpt_plane
);

  logic [W-1:0]     prev_spare;
  logic [PW-1:0]    tgt_plane;
  logic             mism;
  logic [N_ACT-1:0] hit_vec;
  logic [N_ACT-1:0] cnt_nz;
  logic [N_ACT-1:0] seen_q;
  logic [N_ACT-1:0] bad_now;
  logic [N_ACT-1:0] seen_now;
  logic [WIN_W-1:0] win_cnt;
  logic [WIN_W:0]   win_next;
  logic             win_done;

  // location rule: returns {status, plane}
  function automatic logic [PW+1:0] locate(input logic [N_ACT-1:0] bad,
                                           input logic [N_ACT-1:0] seen);
    int unsigned   n;
    logic [PW-1:0] idx;
    n   = 0;
    idx = '0;
    for (int i = 0; i < N_ACT; i++) begin
      if (bad[i]) begin
        n++;
        idx = PW'(i);
      end
    end
    if (n == 0) return {ST_NONE, {PW{1'b0}}};
    if (n >= 2) return {ST_SPARE, {PW{1'b0}}};
    if (&seen)  return {ST_ACTIVE, idx};
    return {ST_AMBIG, idx};
  endfunction

  pc_route #(.N_ACT(N_ACT), .W(W), .IDX_W(IDX_W), .PW(PW)) route_i (
    .act_words (act_words),
    .spare_word(spare_word),
    .prev_spare(prev_spare),
    .bit_idx   (bit_idx),
    .cmp_mode  (cmp_mode),
    .user_words(user_words),
    .tgt_plane (tgt_plane),
    .mism      (mism)
  );

  always_comb begin
    for (int i = 0; i < N_ACT; i++)
      hit_vec[i] = in_valid && (tgt_plane == PW'(i));
  end

  assign bad_now  = cnt_nz | (hit_vec & {N_ACT{mism}});
  assign seen_now = seen_q | hit_vec;

  assign win_next = {1'b0, win_cnt} + {{WIN_W{1'b0}}, 1'b1};
  assign win_done = in_valid && (win_next >= {1'b0, win_len});

  pc_tally #(.N_ACT(N_ACT), .CNT_W(CNT_W)) tally_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit_vec(hit_vec),
    .mism   (mism),
    .clear  (win_done),
    .cnt_nz (cnt_nz),
    .seen_q (seen_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_spare <= '0;
      win_cnt    <= '0;
      rpt_valid  <= 1'b0;
      rpt_status <= 2'd0;
      rpt_plane  <= '0;
    end else begin
      if (in_valid) prev_spare <= spare_word;
      if (win_done)      win_cnt <= '0;
      else if (in_valid) win_cnt <= win_next[WIN_W-1:0];
      rpt_valid <= win_done;
      if (win_done) {rpt_status, rpt_plane} <= locate(bad_now, seen_now);
    end
  end

endmodule

// File: rtl/plane_check_sva.sv
module plane_check_sva #(
  parameter int N_ACT = 4,
  parameter int W     = 4,
  parameter int PW    = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               cmp_mode,
  input logic               bit_lsb,
  input logic [N_ACT*W-1:0] act_words,
  input logic [W-1:0]       spare_word,
  input logic [N_ACT*W-1:0] user_words,
  input logic [PW-1:0]      tgt_plane,
  input logic               win_done,
  input logic [N_ACT-1:0]   cnt_nz,
  input logic [N_ACT-1:0]   seen_q,
  input logic               rpt_valid,
  input logic [1:0]         rpt_status,
  input logic [PW-1:0]      rpt_plane
);

  assert_pulse_after_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |-> $past(in_valid));

  assert_copy_passthrough_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cmp_mode) |-> (user_words == act_words));

  assert_comp_restore_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cmp_mode && bit_lsb) |-> (user_words[tgt_plane*W +: W] == spare_word));

  assert_clear_on_close_R10: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> ((cnt_nz == '0) && (seen_q == '0)));

  assert_plane_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && (rpt_status == 2'd0 || rpt_status == 2'd2)) |-> (rpt_plane == '0));

  assert_plane_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && rpt_status[0]) |-> (32'(rpt_plane) < N_ACT));

endmodule

bind plane_check_top plane_check_sva #(.N_ACT(N_ACT), .W(W), .PW(PW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .cmp_mode  (cmp_mode),
  .bit_lsb   (bit_idx[0]),
  .act_words (act_words),
  .spare_word(spare_word),
  .user_words(user_words),
  .tgt_plane (tgt_plane),
  .win_done  (win_done),
  .cnt_nz    (cnt_nz),
  .seen_q    (seen_q),
  .rpt_valid (rpt_valid),
  .rpt_status(rpt_status),
  .rpt_plane (rpt_plane)
);

// File: tb/plane_check_top_tb_top.sv
`timescale 1ns/1ps
module plane_check_top_tb_top;

  localparam int M = 4;
  localparam int W = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            cmp_mode = 1'b0;
  logic [15:0]     bit_idx = '0;
  logic [15:0]     win_len = 16'd8;
  logic [M*W-1:0]  act_words = '0;
  logic [W-1:0]    spare_word = '0;
  logic [M*W-1:0]  user_words;
  logic            rpt_valid;
  logic [1:0]      rpt_status;
  logic [1:0]      rpt_plane;

  int nchecks = 0;
  int nerr = 0;
  bit finished = 0;
  logic [W-1:0] prev_true = '0;

  always #4 clk = ~clk;

  plane_check_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cmp_mode(cmp_mode),
    .bit_idx(bit_idx), .win_len(win_len), .act_words(act_words),
    .spare_word(spare_word), .user_words(user_words), .rpt_valid(rpt_valid),
    .rpt_status(rpt_status), .rpt_plane(rpt_plane)
  );

  // mode, window length, fault mask (bit 4 = spare), expected status, plane
  typedef struct packed {
    logic        mode;
    logic [15:0] win;
    logic [4:0]  mask;
    logic [1:0]  st;
    logic [1:0]  pl;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'd8, 5'h00, 2'd0, 2'd0},  // R6
    '{1'b0, 16'd8, 5'h04, 2'd1, 2'd2},  // R7 R1
    '{1'b0, 16'd8, 5'h00, 2'd0, 2'd0},  // R10 clean after faulty
    '{1'b0, 16'd8, 5'h10, 2'd2, 2'd0},  // R8 spare
    '{1'b0, 16'd8, 5'h03, 2'd2, 2'd0},  // R8 two planes
    '{1'b0, 16'd3, 5'h02, 2'd3, 2'd1},  // R9
    '{1'b0, 16'd3, 5'h08, 2'd0, 2'd0},  // R1 plane 3 never compared
    '{1'b1, 16'd8, 5'h00, 2'd0, 2'd0},  // R3
    '{1'b1, 16'd8, 5'h08, 2'd1, 2'd3},  // R3
    '{1'b1, 16'd8, 5'h10, 2'd2, 2'd0},  // R3 spare
    '{1'b1, 16'd4, 5'h01, 2'd3, 2'd0},  // R9 complement
    '{1'b0, 16'd0, 5'h00, 2'd0, 2'd0},  // R5 zero length
    '{1'b0, 16'd1, 5'h01, 2'd3, 2'd0}   // R9 single word
  };

  function automatic logic [W-1:0] dat(input int t, input int p);
    return W'((t * 7 + p * 5 + 3) ^ (t >> 2));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
    end
  endtask

  // drive one accepted cycle at index t and check combinational outputs
  task automatic drive_cycle(input int t, input logic mode, input logic [4:0] mask);
    int tgt;
    bit odd;
    logic [M*W-1:0] a;
    logic [W-1:0] sp;
    logic [M*W-1:0] exp_u;
    tgt = mode ? ((t / 2) % M) : (t % M);
    odd = mode && (t % 2 == 1);
    @(negedge clk);
    for (int p = 0; p < M; p++) a[p*W +: W] = dat(t, p);
    sp = dat(t, tgt);
    if (odd) a[tgt*W +: W] = ~prev_true;
    prev_true = sp;
    if (mask[tgt]) a[tgt*W] = ~a[tgt*W];
    if (mask[4]) sp[0] = ~sp[0];
    in_valid = 1'b1; cmp_mode = mode; bit_idx = 16'(t);
    act_words = a; spare_word = sp;
    #1;
    exp_u = a;
    if (odd) exp_u[tgt*W +: W] = sp;
    chk(user_words == exp_u, mode ? "R4" : "R2", "user_words",
        int'(user_words), int'(exp_u));
    chk(rpt_valid == 1'b0, "R5", "rpt_valid inside window", int'(rpt_valid), 0);
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_report(input logic [1:0] st, input logic [1:0] pl, input string req);
    idle_cycle();
    chk(rpt_valid == 1'b1, "R5", "rpt_valid at close", int'(rpt_valid), 1);
    chk(rpt_status == st, req, "rpt_status", int'(rpt_status), int'(st));
    chk(rpt_plane == pl, req, "rpt_plane", int'(rpt_plane), int'(pl));
    idle_cycle();
    chk(rpt_valid == 1'b0, "R5", "rpt_valid drops", int'(rpt_valid), 0);
  endtask

  task automatic run_window(input logic mode, input logic [15:0] win,
                            input logic [4:0] mask, input logic [1:0] st,
                            input logic [1:0] pl, input string req);
    int n;
    n = (win == 0) ? 1 : int'(win);
    win_len = win;
    for (int t = 0; t < n; t++) drive_cycle(t, mode, mask);
    check_report(st, pl, req);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nchecks++;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R12 reset state
    chk(rpt_valid == 1'b0, "R12", "rpt_valid after reset", int'(rpt_valid), 0);
    chk(rpt_status == 2'd0, "R12", "rpt_status after reset", int'(rpt_status), 0);
    chk(rpt_plane == 2'd0, "R12", "rpt_plane after reset", int'(rpt_plane), 0);

    for (int v = 0; v < NV; v++)
      run_window(VECS[v].mode, VECS[v].win, VECS[v].mask, VECS[v].st, VECS[v].pl,
                 $sformatf("R6-table vector %0d", v));

    // R5: gap cycles do not count toward the window
    win_len = 16'd4;
    for (int t = 0; t < 3; t++) begin
      drive_cycle(t, 1'b0, 5'h00);
      idle_cycle();
      chk(rpt_valid == 1'b0, "R5", "no close during gaps", int'(rpt_valid), 0);
    end
    drive_cycle(3, 1'b0, 5'h00);
    check_report(2'd0, 2'd0, "R5");

    // R10: faulty window then clean window
    run_window(1'b0, 16'd8, 5'h02, 2'd1, 2'd1, "R10");
    run_window(1'b0, 16'd8, 5'h00, 2'd0, 2'd0, "R10");

    // R11: 256 mismatches on plane 0 must not wrap the counter
    run_window(1'b0, 16'd1024, 5'h01, 2'd1, 2'd0, "R11");

    finish_run();
  end

endmodule